// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is an 8-bit timer that counts up from zero to its maximum and then back down to zero. It drives two waveform outputs, A and B, whose pulses are centred on the bottom of each sweep. Each channel compares the running count with its own compare value. The channel clears or sets its pin when the count lands on that value, and the direction of travel picks which. The pin levels at the two turnaround points are forced so that the waveform stays mirror-symmetric about the bottom, even when a compare value is at an extreme or has just changed.

A prescaler turns the system clock into a one-cycle enable. The whole block runs on the system clock and makes no derived clock. Compare values written at the inputs reach the active compare registers only when the count lands on its maximum, so a period never starts with one value and ends with another. Three sticky flags report bottom arrivals and compare hits. Software clears them with write-one-to-clear strobes.

Top module: `pwm_pc_timer`

## Requirements
- R1: While `rst` is high at a clock edge, both pins and all three flags go to 0, the count goes to 0 with upward travel, and both active compare values go to 0.
- R2: `clk_sel` picks the enable rate. The codes 1, 2, 3, 4 and 5 give one step every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop the count, so no flag sets. One full output period therefore lasts 510·N clocks.
- R3: Each enabled step moves the count by one. It climbs 0→255, turns at 255 and falls back to 0, and never holds an endpoint for two steps. Bottom arrivals are therefore 510 steps apart.
- R4: In mode `2'b10` (non-inverted) the pin clears when the count lands on the compare value k while climbing, and sets when it lands on k while falling. For 0<k<255 at /1, the pin is high for 2k clocks of every 510.
- R5: Mode `2'b11` (inverted) drives the complement of the non-inverted level. For 0<k<255 at /1, the pin is high for 510−2k clocks of every 510.
- R6: In the steady state, compare value 0 holds a non-inverted pin low and 255 holds it high. In inverted mode the same values give the opposite constant levels.
- R7: When the compare value moves from 255 to 0, the non-inverted pin stays high through the next top and the falling slope. It drops on the step that lands on 0.
- R8: When a new value k with 0<k<255 takes effect at the top, the non-inverted pin takes the level that a climbing hit on k would have left, which is low, even though the count never landed on k while climbing.
- R9: Mode `2'b01` makes pin A toggle on every landing on its compare value, but only while `toggle_a_en` is 1. Otherwise, and always on pin B, mode `2'b01` drives the pin low, the same as mode `2'b00` (off).
- R10: A compare input takes effect on the step that lands the count on 255. Before that step the old active value still governs the pin.
- R11: `bottom_flag` sets on each step that lands the count on 0. `hit_a_flag` and `hit_b_flag` set on each step that lands the count on the channel's active compare value, in either direction.
- R12: The flags stay set until cleared by `flag_clr`: bit 0 clears `bottom_flag`, bit 1 clears `hit_a_flag` and bit 2 clears `hit_b_flag`. A new set event in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Prescaler select (0 = stopped, 1..5 = /1, /8, /64, /256, /1024) |
| cmp_a | input | 8 | Compare value for channel A, staged until the top |
| cmp_b | input | 8 | Compare value for channel B, staged until the top |
| mode_a | input | 2 | Channel A output mode: 00 off, 01 toggle, 10 non-inverted, 11 inverted |
| mode_b | input | 2 | Channel B output mode (01 behaves as off) |
| toggle_a_en | input | 1 | Permits mode 01 on channel A |
| flag_clr | input | 3 | Write-one-to-clear strobes: bit 0 bottom, bit 1 hit A, bit 2 hit B |
| wave_a | output | 1 | Waveform pin A |
| wave_b | output | 1 | Waveform pin B |
| hit_a_flag | output | 1 | Sticky compare hit flag, channel A |
| hit_b_flag | output | 1 | Sticky compare hit flag, channel B |
| bottom_flag | output | 1 | Sticky bottom arrival flag |

## Verification
The bench builds the timer with its default 8-bit count. A full sweep is then 510 steps, so duty counts of exactly 2k, the extremes 0 and 255, and the neighbours 1 and 254 can all be measured inside a single 510-clock window. Period checks run at the /1, /8 and /64 rates. The /256 and /1024 rates use the same mask path, but their periods fall outside the run length. With the default width, the clock-exact timing of the turnaround cases fits in a few hundred cycles: the late drop after a move away from 255, the missed climbing hit, and the staging of compare values at the top.

// File: rtl/pwm_pc_pkg.sv
package pwm_pc_pkg;

    // Width of the free-running prescaler divider (covers /1024)
    localparam int PRESC_W = 10;

    // Output mode encodings for a waveform channel
    typedef enum logic [1:0] {
        WM_OFF      = 2'b00,
        WM_TOGGLE   = 2'b01,
        WM_CLEAR_UP = 2'b10,
        WM_SET_UP   = 2'b11
    } wave_mode_e;

    // Events produced by the sweep counter on an enabled step
    typedef struct packed {
        logic tick;       // an enabled step happens this cycle
        logic rising;     // the step travels upward
        logic at_top;     // the step lands on the maximum
        logic at_bottom;  // the step lands on zero
    } sweep_ev_t;

    function automatic logic presc_on(input logic [2:0] sel);
        return (sel != 3'd0) && (sel <= 3'd5);
    endfunction

    // Low-bit mask whose all-ones state marks one enable per divide period
    function automatic logic [PRESC_W-1:0] presc_mask(input logic [2:0] sel);
        logic [PRESC_W-1:0] m;
        case (sel)
            3'd2:    m = PRESC_W'(7);
            3'd3:    m = PRESC_W'(63);
            3'd4:    m = PRESC_W'(255);
            3'd5:    m = PRESC_W'(1023);
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pwm_pc_prescale.sv
module pwm_pc_prescale
    import pwm_pc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PRESC_W-1:0] div_q;
    logic [PRESC_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    assign mask = presc_mask(sel);
    assign tick = presc_on(sel) && ((div_q & mask) == mask);

    // R2: a stopped select never produces a step
    a_r2_stopped: assert property (@(posedge clk) disable iff (rst)
        (!presc_on(sel)) |-> !tick);

    // R2: divide-by-8 never yields two steps in a row
    a_r2_div8_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && sel == 3'd2 && $past(sel) == 3'd2) |-> !$past(tick));

endmodule

// File: rtl/pwm_pc_sweep.sv
module pwm_pc_sweep
    import pwm_pc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] land,
    output sweep_ev_t        ev
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             up_q;
    logic             up_nxt;

    always_comb begin
        land   = up_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
        up_nxt = up_q;
        if (land == TOP)       up_nxt = 1'b0;
        else if (land == '0)   up_nxt = 1'b1;
    end

    always_comb begin
        ev.tick      = tick;
        ev.rising    = up_q;
        ev.at_top    = tick && (land == TOP);
        ev.at_bottom = tick && (land == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (tick) begin
            cnt_q <= land;
            up_q  <= up_nxt;
        end
    end

    // R3: the count holds without an enable
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    // R3: each step moves by exactly one
    a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));

    // R3: turnaround at the maximum, no repeated endpoint
    a_r3_top_turn: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == TOP) |=> cnt_q == TOP - 1'b1);

    // R3: turnaround at zero, no repeated endpoint
    a_r3_bottom_turn: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == '0) |=> cnt_q == CNT_W'(1));

endmodule

// File: rtl/pwm_pc_channel.sv
module pwm_pc_channel
    import pwm_pc_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter bit ALLOW_TOGGLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  sweep_ev_t        ev,
    input  logic [CNT_W-1:0] land,
    input  logic [CNT_W-1:0] cmp_in,
    input  wave_mode_e       mode,
    input  logic             toggle_en,
    input  logic             clr,
    output logic             wave,
    output logic             hit_flag
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cmp_act_q;
    logic [CNT_W-1:0] cmp_eff;
    logic             hit;
    logic             lvl_q;
    logic             tog_q;
    logic             tog_ok;

    // Staged compare value becomes active on the step landing on the maximum
    assign cmp_eff = ev.at_top ? cmp_in : cmp_act_q;
    assign hit     = ev.tick && (land == cmp_eff);
    assign tog_ok  = ALLOW_TOGGLE && toggle_en && (mode == WM_TOGGLE);

    always_ff @(posedge clk) begin
        if (rst) cmp_act_q <= '0;
        else if (ev.at_top) cmp_act_q <= cmp_in;
    end

    // Non-inverted level: endpoint forcing keeps symmetry about zero
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
        end else if (ev.tick) begin
            if (ev.at_bottom) begin
                lvl_q <= (cmp_eff != '0);
            end else if (ev.at_top) begin
                if (cmp_eff == TOP)      lvl_q <= 1'b1;
                else if (cmp_eff != '0)  lvl_q <= 1'b0;
            end else if (hit) begin
                lvl_q <= !ev.rising;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                tog_q <= 1'b0;
        else if (hit && tog_ok) tog_q <= !tog_q;
    end

    always_ff @(posedge clk) begin
        if (rst)      hit_flag <= 1'b0;
        else if (hit) hit_flag <= 1'b1;
        else if (clr) hit_flag <= 1'b0;
    end

    always_comb begin
        case (mode)
            WM_TOGGLE:   wave = tog_ok ? tog_q : 1'b0;
            WM_CLEAR_UP: wave = lvl_q;
            WM_SET_UP:   wave = !lvl_q;
            default:     wave = 1'b0;
        endcase
    end

    // R6: an active maximum compare keeps the level high
    a_r6_max_high: assert property (@(posedge clk) disable iff (rst)
        (ev.tick && cmp_eff == TOP) |=> lvl_q);

    // R7: a zero compare leaves the level low after a bottom arrival
    a_r7_bottom_low: assert property (@(posedge clk) disable iff (rst)
        (ev.at_bottom && cmp_eff == '0) |=> !lvl_q);

    // R9: the toggle state only moves when toggling is permitted
    a_r9_toggle_gate: assert property (@(posedge clk) disable iff (rst)
        !tog_ok |=> $stable(tog_q));

    // R11 / R12: a hit sets the flag even with a clear present
    a_r11_hit_sets: assert property (@(posedge clk) disable iff (rst)
        hit |=> hit_flag);

    // R10: active value changes only at the top landing
    a_r10_staged: assert property (@(posedge clk) disable iff (rst)
        !ev.at_top |=> $stable(cmp_act_q));

endmodule

// File: rtl/pwm_pc_timer.sv
module pwm_pc_timer
    import pwm_pc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       clk_sel,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [1:0]       mode_a,
    input  logic [1:0]       mode_b,
    input  logic             toggle_a_en,
    input  logic [2:0]       flag_clr,
    output logic             wave_a,
    output logic             wave_b,
    output logic             hit_a_flag,
    output logic             hit_b_flag,
    output logic             bottom_flag
);

    localparam int N_CH = 2;

    logic             tick;
    logic [CNT_W-1:0] land;
    sweep_ev_t        ev;

    logic [CNT_W-1:0] cmp_arr  [N_CH];
    logic [1:0]       mode_arr [N_CH];
    logic [N_CH-1:0]  wave_arr;
    logic [N_CH-1:0]  hit_arr;

    assign cmp_arr[0]  = cmp_a;
    assign cmp_arr[1]  = cmp_b;
    assign mode_arr[0] = mode_a;
    assign mode_arr[1] = mode_b;

    pwm_pc_prescale u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (clk_sel),
        .tick (tick)
    );

    pwm_pc_sweep #(.CNT_W(CNT_W)) u_sweep (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .land (land),
        .ev   (ev)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm_pc_channel #(
            .CNT_W        (CNT_W),
            .ALLOW_TOGGLE (g == 0)
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .ev        (ev),
            .land      (land),
            .cmp_in    (cmp_arr[g]),
            .mode      (wave_mode_e'(mode_arr[g])),
            .toggle_en (toggle_a_en),
            .clr       (flag_clr[g+1]),
            .wave      (wave_arr[g]),
            .hit_flag  (hit_arr[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)               bottom_flag <= 1'b0;
        else if (ev.at_bottom) bottom_flag <= 1'b1;
        else if (flag_clr[0])  bottom_flag <= 1'b0;
    end

    assign wave_a     = wave_arr[0];
    assign wave_b     = wave_arr[1];
    assign hit_a_flag = hit_arr[0];
    assign hit_b_flag = hit_arr[1];

    // R11: a bottom arrival always raises the flag
    a_r11_bottom_sets: assert property (@(posedge clk) disable iff (rst)
        ev.at_bottom |=> bottom_flag);

    // R12: without a bottom arrival a clear empties the flag
    a_r12_bottom_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[0] && !ev.at_bottom) |=> !bottom_flag);

    // R1: reset leaves flags and pins idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> !bottom_flag && !hit_a_flag && !hit_b_flag);

endmodule

// File: tb/pwm_pc_timer_bench.sv
module pwm_pc_timer_bench;

    logic       clk;
    logic       rst;
    logic [2:0] clk_sel;
    logic [7:0] cmp_a, cmp_b;
    logic [1:0] mode_a, mode_b;
    logic       toggle_a_en;
    logic [2:0] flag_clr;
    logic       wave_a, wave_b, hit_a_flag, hit_b_flag, bottom_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    pwm_pc_timer u_pwm_pc_timer (
        .clk(clk), .rst(rst), .clk_sel(clk_sel),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .mode_a(mode_a), .mode_b(mode_b),
        .toggle_a_en(toggle_a_en), .flag_clr(flag_clr),
        .wave_a(wave_a), .wave_b(wave_b),
        .hit_a_flag(hit_a_flag), .hit_b_flag(hit_b_flag),
        .bottom_flag(bottom_flag)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    typedef struct packed {
        logic [7:0] ka;
        logic [1:0] ma;
        logic [7:0] kb;
        logic [1:0] mb;
        logic [9:0] ea;
        logic [9:0] eb;
    } vec_t;

    // duty table: high clocks per 510-clock window at /1
    localparam vec_t VECS [0:4] = '{
        '{8'd100, 2'b10, 8'd100, 2'b11, 10'd200, 10'd310},
        '{8'd0,   2'b10, 8'd255, 2'b11, 10'd0,   10'd0},
        '{8'd255, 2'b10, 8'd0,   2'b11, 10'd510, 10'd510},
        '{8'd1,   2'b10, 8'd254, 2'b10, 10'd2,   10'd508},
        '{8'd254, 2'b11, 8'd37,  2'b10, 10'd2,   10'd74}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_bottom();
        int w = 0;
        while (!bottom_flag && w < 70000) begin
            @(negedge clk);
            w++;
        end
    endtask

    // gap in clocks between two successive bottom arrivals
    task automatic bottom_gap(output int gap);
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        wait_bottom();
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        gap = 1;
        while (!bottom_flag && gap < 70000) begin
            @(negedge clk);
            gap++;
        end
    endtask

    task automatic measure(output int hi_a, output int hi_b, output int edges_a);
        logic prev_a;
        hi_a = 0; hi_b = 0; edges_a = 0;
        prev_a = wave_a;
        for (int i = 0; i < 510; i++) begin
            @(negedge clk);
            hi_a += int'(wave_a);
            hi_b += int'(wave_b);
            if (wave_a != prev_a) edges_a++;
            prev_a = wave_a;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int gap, ha, hb, ea;
        bit seen;
        rst = 1'b1; clk_sel = 3'd1; cmp_a = 8'd0; cmp_b = 8'd0;
        mode_a = 2'b00; mode_b = 2'b00; toggle_a_en = 1'b0; flag_clr = 3'b000;
        step(3);
        // R1: reset state
        check(wave_a == 1'b0, "R1 wave_a in reset", int'(wave_a), 0);
        check(wave_b == 1'b0, "R1 wave_b in reset", int'(wave_b), 0);
        check(bottom_flag == 1'b0, "R1 bottom_flag in reset", int'(bottom_flag), 0);
        check(hit_a_flag == 1'b0 && hit_b_flag == 1'b0, "R1 hit flags in reset",
              int'({hit_a_flag, hit_b_flag}), 0);
        rst = 1'b0;

        // R3: full sweep is 510 steps at /1
        bottom_gap(gap);
        check(gap == 510, "R3 sweep length at /1", gap, 510);

        // R2: prescaled periods
        clk_sel = 3'd2;
        bottom_gap(gap);
        check(gap == 4080, "R2 period at /8", gap, 4080);
        clk_sel = 3'd3;
        bottom_gap(gap);
        check(gap == 32640, "R2 period at /64", gap, 32640);

        // R2: stopped select leaves flags untouched
        clk_sel = 3'd0;
        @(negedge clk);
        flag_clr = 3'b111;
        @(negedge clk);
        flag_clr = 3'b000;
        step(3000);
        check(!bottom_flag && !hit_a_flag && !hit_b_flag, "R2 stopped select sets no flag",
              int'({bottom_flag, hit_a_flag, hit_b_flag}), 0);
        clk_sel = 3'd1;

        // R4 R5 R6: duty table walk
        foreach (VECS[v]) begin
            cmp_a = VECS[v].ka; mode_a = VECS[v].ma;
            cmp_b = VECS[v].kb; mode_b = VECS[v].mb;
            step(1100);
            measure(ha, hb, ea);
            check(ha == int'(VECS[v].ea), $sformatf("R4/R5/R6 duty A vector %0d", v), ha, int'(VECS[v].ea));
            check(hb == int'(VECS[v].eb), $sformatf("R4/R5/R6 duty B vector %0d", v), hb, int'(VECS[v].eb));
        end

        // R9: toggle on A when permitted
        cmp_a = 8'd60; mode_a = 2'b01; toggle_a_en = 1'b1;
        cmp_b = 8'd60; mode_b = 2'b01;
        step(1100);
        measure(ha, hb, ea);
        check(ea == 2, "R9 toggle edges per period on A", ea, 2);
        check(ha == 120 || ha == 390, "R9 toggle high time on A", ha, 120);
        check(hb == 0, "R9 toggle refused on B", hb, 0);
        toggle_a_en = 1'b0;
        measure(ha, hb, ea);
        check(ha == 0, "R9 toggle on A without enable stays low", ha, 0);

        // R7: move from 255 to 0 drops the pin at the next bottom
        mode_a = 2'b10; mode_b = 2'b00; cmp_a = 8'd255;
        step(600);
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        wait_bottom();
        cmp_a = 8'd0;
        flag_clr = 3'b001;
        for (int i = 1; i <= 510; i++) begin
            @(negedge clk);
            flag_clr = 3'b000;
            if (i == 255) check(wave_a == 1'b1, "R7 high at top after move to 0", int'(wave_a), 1);
            if (i == 509) check(wave_a == 1'b1, "R7 high just before bottom", int'(wave_a), 1);
            if (i == 510) check(wave_a == 1'b0, "R7 low at bottom", int'(wave_a), 0);
        end

        // R8 R10: move from 255 to 50 forces the missed climbing level at the top
        cmp_a = 8'd255;
        step(600);
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        wait_bottom();
        cmp_a = 8'd50;
        flag_clr = 3'b011;
        for (int i = 1; i <= 460; i++) begin
            @(negedge clk);
            flag_clr = 3'b000;
            if (i == 254) check(wave_a == 1'b1, "R10 old value still governs before top", int'(wave_a), 1);
            if (i == 255) check(wave_a == 1'b0, "R8 forced low at top", int'(wave_a), 0);
            if (i == 459) check(wave_a == 1'b0 && !hit_a_flag, "R11 no hit before landing on 50",
                                int'({wave_a, hit_a_flag}), 0);
            if (i == 460) begin
                check(wave_a == 1'b1, "R4 set on falling hit", int'(wave_a), 1);
                check(hit_a_flag == 1'b1, "R11 hit flag on falling landing", int'(hit_a_flag), 1);
            end
        end

        // R12: sticky until cleared, then cleared
        flag_clr = 3'b010;
        @(negedge clk);
        flag_clr = 3'b000;
        while (!hit_a_flag) @(negedge clk);
        step(90);
        check(hit_a_flag == 1'b1, "R12 flag stays set", int'(hit_a_flag), 1);
        flag_clr = 3'b010;
        @(negedge clk);
        flag_clr = 3'b000;
        check(hit_a_flag == 1'b0, "R12 clear empties flag", int'(hit_a_flag), 0);

        // R12: set wins over a clear held high
        flag_clr = 3'b010;
        seen = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (hit_a_flag) seen = 1'b1;
        end
        flag_clr = 3'b000;
        check(seen, "R12 hit seen despite held clear", int'(seen), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule